// File: doc/BRIEF.md
# Single-Precision to 32-bit Integer Converter with Saturation

This block takes one IEEE single-precision operand and turns it into a 32-bit integer, either signed (two's complement) or unsigned, under one of four rounding modes chosen per operation. Beside the integer it reports two exception flags: invalid, for operands with no representable result, and inexact, for results that dropped a nonzero fraction. Values that do not fit, infinities and NaNs produce fixed saturated codes instead of wrapping.

Operands enter through a valid/ready handshake. With the default `REG_OUT = 1` the result appears one cycle after acceptance in an output register. The register keeps its contents while the consumer stalls, and a new operand can be accepted in the cycle the previous result leaves. With `REG_OUT = 0` the converter is purely combinational, and the handshake signals pass straight through.

Top module: `fp32_to_int_cvt`

## Requirements
- R1: `in_rmode` selects rounding: 2'b00 to nearest with ties to even, 2'b01 toward zero, 2'b10 toward minus infinity, 2'b11 toward plus infinity; in-range results equal the operand rounded that way. The operand uses bit 31 as sign, bits 30:23 as biased exponent and bits 22:0 as fraction.
- R2: For an in-range result, `out_inexact` is 1 exactly when the operand had a nonzero fraction part, whether the result was rounded up or truncated. Exact results, including zeros, raise no flag.
- R3: A NaN operand (quiet or signalling) raises invalid and yields 32'h7FFFFFFF for a signed conversion and 32'hFFFFFFFF for an unsigned one.
- R4: In a signed conversion, a rounded value above 2^31-1 (including +infinity) yields 32'h7FFFFFFF, and one below -2^31 (including -infinity) yields 32'h80000000, both raising invalid. Exactly -2^31 converts without flags.
- R5: In an unsigned conversion, a rounded value above 2^32-1 (including +infinity) yields 32'hFFFFFFFF and raises invalid.
- R6: In an unsigned conversion, a negative non-NaN operand whose rounded magnitude is nonzero (including -infinity) yields 0 and raises invalid. A negative operand that rounds to zero yields 0 and raises only inexact if fraction bits were lost. Negative zero gives 0 with no flags.
- R7: `out_invalid` and `out_inexact` are never both 1.
- R8: With `REG_OUT = 1`, an operand accepted on a clock edge produces its result on the next edge. `in_ready` is high whenever the output register is empty or being drained. A stalled result keeps its value and flags until it is taken, and results leave in acceptance order.
- R9: During and right after reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_bits | input | 32 | Single-precision operand |
| in_unsigned | input | 1 | 1 selects unsigned result, 0 signed |
| in_rmode | input | 2 | Rounding mode, encoding in R1 |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_int | output | 32 | Integer result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
Checked on every cycle by the assertions:
- the two flags are mutually exclusive;
- a stalled result does not change;
- any NaN and either infinity map to their saturation codes one cycle after acceptance;
- an unsigned conversion of an operand at or below -1.0 returns 0 with invalid.

Covered only by the scoreboard scenarios:
- rounding that depends on the discarded bits: ties to even, directed rounding of negative values, and subnormals rounding up to 1;
- the exact range edges at 2^31 and 2^32;
- the split between negative operands that round to zero and those that do not.

// File: rtl/fp32_to_int_cvt.sv
module fp32_to_int_cvt #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_bits,
  input  logic        in_unsigned,
  input  logic [1:0]  in_rmode,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_int,
  output logic        out_invalid,
  output logic        out_inexact
);
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int INT_W  = 32;
  localparam int MANT_W = FRAC_W + 1;
  localparam int SHW_W  = INT_W + MANT_W;
  localparam logic [EXP_W-1:0] EXP_HALF = 8'd126;
  localparam logic [EXP_W-1:0] EXP_HUGE = 8'd159;

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic              is_nan, is_huge, is_small;
  logic [EXP_W-1:0]  sh;
  logic [SHW_W-1:0]  shifted;
  logic [INT_W-1:0]  ipart;
  logic              half, stk, lost, inc;
  logic [INT_W:0]    mag;
  logic [INT_W-1:0]  res;
  logic              inv, inx;

  assign sgn      = in_bits[31];
  assign ex       = in_bits[30:23];
  assign fr       = in_bits[22:0];
  assign is_nan   = (&ex) && (|fr);
  assign is_huge  = ex >= EXP_HUGE;
  assign is_small = ex < EXP_HALF;
  assign sh       = ex - EXP_HALF;
  assign shifted  = {{INT_W{1'b0}}, (|ex), fr} << sh[5:0];
  assign ipart    = is_small ? '0 : shifted[SHW_W-1:MANT_W];
  assign half     = is_small ? 1'b0 : shifted[MANT_W-1];
  assign stk      = is_small ? (|in_bits[30:0]) : (|shifted[MANT_W-2:0]);
  assign lost     = half | stk;

  always_comb begin
    case (in_rmode)
      2'b00:   inc = half & (stk | ipart[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = sgn & lost;
      default: inc = ~sgn & lost;
    endcase
  end

  assign mag = {1'b0, ipart} + {{INT_W{1'b0}}, inc};

  always_comb begin
    inv = 1'b0;
    res = '0;
    if (is_nan) begin
      inv = 1'b1;
      res = in_unsigned ? '1 : 32'h7FFF_FFFF;
    end else if (in_unsigned) begin
      if (sgn) begin
        inv = is_huge || (mag != '0);
      end else if (is_huge || mag[INT_W]) begin
        inv = 1'b1;
        res = '1;
      end else begin
        res = mag[INT_W-1:0];
      end
    end else if (sgn) begin
      if (is_huge || mag > 33'h0_8000_0000) begin
        inv = 1'b1;
        res = 32'h8000_0000;
      end else begin
        res = -mag[INT_W-1:0];
      end
    end else if (is_huge || mag > 33'h0_7FFF_FFFF) begin
      inv = 1'b1;
      res = 32'h7FFF_FFFF;
    end else begin
      res = mag[INT_W-1:0];
    end
  end

  assign inx = lost & ~inv;

  generate
    if (REG_OUT) begin : g_reg
      assign in_ready = ~out_valid | out_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid   <= 1'b0;
          out_int     <= '0;
          out_invalid <= 1'b0;
          out_inexact <= 1'b0;
        end else if (in_ready) begin
          out_valid <= in_valid;
          if (in_valid) begin
            out_int     <= res;
            out_invalid <= inv;
            out_inexact <= inx;
          end
        end
      end

      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_int)
                                   && $stable(out_invalid) && $stable(out_inexact));

      assert_nan_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && (&in_bits[30:23]) && (|in_bits[22:0])
        |=> out_valid && out_invalid && (&out_int[30:0]));

      assert_pinf_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_unsigned && in_bits == 32'h7F80_0000
        |=> out_invalid && out_int == 32'h7FFF_FFFF);

      assert_ninf_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_unsigned && in_bits == 32'hFF80_0000
        |=> out_invalid && out_int == 32'h8000_0000);

      assert_uinf_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_unsigned && in_bits == 32'h7F80_0000
        |=> out_invalid && out_int == 32'hFFFF_FFFF);

      assert_uneg_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_unsigned && in_bits[31]
        && in_bits[30:23] >= 8'd127 && !((&in_bits[30:23]) && (|in_bits[22:0]))
        |=> out_invalid && out_int == '0);

      assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_invalid && out_inexact));
    end else begin : g_comb
      assign in_ready    = out_ready;
      assign out_valid   = in_valid;
      assign out_int     = res;
      assign out_invalid = inv;
      assign out_inexact = inx;
    end
  endgenerate
endmodule

// File: tb/fp32_to_int_cvt_tb.sv
module fp32_to_int_cvt_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_bits;
  logic        in_unsigned;
  logic [1:0]  in_rmode;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_int;
  logic        out_invalid;
  logic        out_inexact;

  int          total = 0;
  int          bad = 0;
  int          sent = 0;
  int          recv = 0;
  bit          finished = 1'b0;
  bit          stall_on = 1'b0;
  logic [7:0]  lfsr;
  logic [33:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  fp32_to_int_cvt #(.REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .in_unsigned(in_unsigned), .in_rmode(in_rmode),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_int(out_int), .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr      <= 8'hA5;
      out_ready <= 1'b0;
    end else begin
      lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready <= !stall_on || lfsr[0];
    end
  end

  task automatic send(input logic [31:0] b, input logic u, input logic [1:0] m,
                      input logic [31:0] ei, input logic ev, input logic ex,
                      input string tag);
    @(negedge clk);
    in_bits = b; in_unsigned = u; in_rmode = m; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back({ei, ev, ex});
    tag_q.push_back(tag);
    sent++;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid && out_ready) begin
      total++;
      recv++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R8: got unexpected result %h, expected none", out_int);
      end else begin
        logic [33:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({out_int, out_invalid, out_inexact} !== e) begin
          bad++;
          $display("FAIL %s: got int=%h inv=%b inx=%b expected int=%h inv=%b inx=%b",
                   t, out_int, out_invalid, out_inexact, e[33:2], e[1], e[0]);
        end
      end
    end
  end

  task automatic run_vectors();
    send(32'h3FC00000, 1'b0, 2'b00, 32'h00000002, 1'b0, 1'b1, "R1 1.5 nearest");
    send(32'h3FC00000, 1'b0, 2'b01, 32'h00000001, 1'b0, 1'b1, "R1 1.5 toward zero");
    send(32'h3FC00000, 1'b0, 2'b10, 32'h00000001, 1'b0, 1'b1, "R1 1.5 down");
    send(32'h3FC00000, 1'b0, 2'b11, 32'h00000002, 1'b0, 1'b1, "R1 1.5 up");
    send(32'h40200000, 1'b0, 2'b00, 32'h00000002, 1'b0, 1'b1, "R1 2.5 tie to even");
    send(32'hBFC00000, 1'b0, 2'b00, 32'hFFFFFFFE, 1'b0, 1'b1, "R1 -1.5 nearest");
    send(32'hBFC00000, 1'b0, 2'b01, 32'hFFFFFFFF, 1'b0, 1'b1, "R1 -1.5 toward zero");
    send(32'hBFC00000, 1'b0, 2'b10, 32'hFFFFFFFE, 1'b0, 1'b1, "R1 -1.5 down");
    send(32'hBFC00000, 1'b0, 2'b11, 32'hFFFFFFFF, 1'b0, 1'b1, "R1 -1.5 up");
    send(32'h3F400000, 1'b0, 2'b00, 32'h00000001, 1'b0, 1'b1, "R1 0.75 nearest");
    send(32'h00000001, 1'b0, 2'b11, 32'h00000001, 1'b0, 1'b1, "R1 subnormal up");
    send(32'h00000001, 1'b0, 2'b00, 32'h00000000, 1'b0, 1'b1, "R2 subnormal nearest");
    send(32'hBE800000, 1'b0, 2'b10, 32'hFFFFFFFF, 1'b0, 1'b1, "R1 -0.25 down");
    send(32'hBE800000, 1'b0, 2'b11, 32'h00000000, 1'b0, 1'b1, "R2 -0.25 up");
    send(32'h42C80000, 1'b0, 2'b00, 32'h00000064, 1'b0, 1'b0, "R2 100.0 exact");
    send(32'h00000000, 1'b0, 2'b00, 32'h00000000, 1'b0, 1'b0, "R2 zero exact");
    send(32'h4EFFFFFF, 1'b0, 2'b00, 32'h7FFFFF80, 1'b0, 1'b0, "R2 largest below 2^31");
    send(32'h7FC00000, 1'b0, 2'b00, 32'h7FFFFFFF, 1'b1, 1'b0, "R3 quiet NaN signed");
    send(32'h7F800001, 1'b0, 2'b01, 32'h7FFFFFFF, 1'b1, 1'b0, "R3 signalling NaN signed");
    send(32'hFFC00000, 1'b1, 2'b00, 32'hFFFFFFFF, 1'b1, 1'b0, "R3 NaN unsigned");
    send(32'h7F800000, 1'b0, 2'b00, 32'h7FFFFFFF, 1'b1, 1'b0, "R4 +inf signed");
    send(32'hFF800000, 1'b0, 2'b00, 32'h80000000, 1'b1, 1'b0, "R4 -inf signed");
    send(32'h4F000000, 1'b0, 2'b00, 32'h7FFFFFFF, 1'b1, 1'b0, "R4 2^31 signed");
    send(32'hCF000000, 1'b0, 2'b00, 32'h80000000, 1'b0, 1'b0, "R4 -2^31 signed exact");
    send(32'hCF000001, 1'b0, 2'b01, 32'h80000000, 1'b1, 1'b0, "R4 below -2^31");
    send(32'h4F000000, 1'b1, 2'b00, 32'h80000000, 1'b0, 1'b0, "R5 2^31 unsigned");
    send(32'h4F7FFFFF, 1'b1, 2'b00, 32'hFFFFFF00, 1'b0, 1'b0, "R5 largest below 2^32");
    send(32'h4F800000, 1'b1, 2'b00, 32'hFFFFFFFF, 1'b1, 1'b0, "R5 2^32 unsigned");
    send(32'h7F800000, 1'b1, 2'b10, 32'hFFFFFFFF, 1'b1, 1'b0, "R5 +inf unsigned");
    send(32'hBF800000, 1'b1, 2'b00, 32'h00000000, 1'b1, 1'b0, "R6 -1.0 unsigned");
    send(32'hFF800000, 1'b1, 2'b00, 32'h00000000, 1'b1, 1'b0, "R6 -inf unsigned");
    send(32'hBF000000, 1'b1, 2'b01, 32'h00000000, 1'b0, 1'b1, "R6 -0.5 toward zero");
    send(32'hBF000000, 1'b1, 2'b00, 32'h00000000, 1'b0, 1'b1, "R6 -0.5 nearest");
    send(32'hBE800000, 1'b1, 2'b11, 32'h00000000, 1'b0, 1'b1, "R6 -0.25 up");
    send(32'h80000000, 1'b1, 2'b00, 32'h00000000, 1'b0, 1'b0, "R6 negative zero");
    send(32'hBF000000, 1'b1, 2'b10, 32'h00000000, 1'b1, 1'b0, "R7 -0.5 down invalid");
    send(32'hBFC00000, 1'b1, 2'b01, 32'h00000000, 1'b1, 1'b0, "R7 -1.5 unsigned");
    send(32'h4F800001, 1'b0, 2'b00, 32'h7FFFFFFF, 1'b1, 1'b0, "R7 huge signed");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_bits = '0; in_unsigned = 1'b0; in_rmode = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R9: out_valid=%b during reset, expected 0", out_valid);
    end
    rst_n = 1'b1;
    #1;
    total++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R8: after reset out_valid=%b in_ready=%b, expected 0 and 1",
               out_valid, in_ready);
    end
    run_vectors();
    stall_on = 1'b1;
    run_vectors();
    stall_on = 1'b0;
    repeat (20) @(negedge clk);
    total++;
    if (recv != sent || exp_q.size() != 0) begin
      bad++;
      $display("FAIL R8: received %0d results, expected %0d", recv, sent);
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule